// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Current Chopper

This block keeps the peak current of an H-bridge below a limit. A comparator outside the block raises `trip_i` when ten times the sense-resistor voltage rises above the reference. When the block accepts such a trip, it starts a one-shot off-time of fixed length. During that off-time it sends the bridge decoder a sequence of decay commands. First the bridge is held fully off for a dead-time. Next it runs fast decay for about 13 percent of the programmed off-time. Slow decay fills the rest. When the off-time expires, drive resumes.

After every switching transition the comparator is blanked, so that reverse-recovery and capacitive spikes cannot cause false trips. The transitions that blank it are the end of an internal off-time and any edge on the external phase or enable inputs. A trip is never accepted while braking, because brake current does not pass through the sense path. If a near-zero current indication arrives during the fast-decay portion, the bridge is put in high impedance so that the current cannot reverse. Off-time and blank-time are given as clock-cycle counts. The dead-time is a parameter. All pins are plain control and status levels or strobes. There is no streaming interface, so no back-pressure applies.

Top module: `chop_ctl`

## Requirements
- R1: After reset, `chop_o` is 0, `decay_o` is 0 (drive) and `trip_pulse_o` is 0.
- R2: A trip is accepted on a clock edge when `trip_i`=1, `enable_i`=1, `brake_i`=0, no off-time is running and the comparator is not blanked. In the following cycle `trip_pulse_o` is 1 for exactly one cycle, and `chop_o` rises in that same cycle.
- R3: After an accepted trip, `chop_o` stays 1 for DEAD_CYC + max(N,1) cycles. N is the value of `off_cnt_i` captured at acceptance.
- R4: During the off-time, `decay_o` is 3 (all switches off) for the first DEAD_CYC cycles. It is then 1 (fast decay) for F cycles, where F = max(1, floor(max(N,1)*13/100)). It is 2 (slow decay) for the remaining max(N,1)-F cycles.
- R5: If `near_zero_i` is 1 in any fast-decay cycle, `decay_o` is 3 in that cycle and in every remaining fast-decay cycle of that off-time, even after `near_zero_i` falls. The slow-decay portion is not affected.
- R6: A change of `phase_i` or `enable_i` blanks the comparator in the cycle of the change and for the next B cycles, where B = `blank_cnt_i`. If `trip_i` is held high from the change onward, `chop_o` first reads 1 at the (B+2)-th falling-edge sample after the change.
- R7: Trips during the off-time are ignored. When the off-time expires, blanking restarts for B cycles. With `trip_i` held high, `chop_o` is low for exactly B+1 samples between two off-times.
- R8: No trip is accepted while `brake_i`=1 or while `enable_i`=0. `chop_o` stays 0 and `decay_o` stays 0.
- R9: Whenever `chop_o` is 0, `decay_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_i | input | 1 | Comparator: sense current above reference |
| phase_i | input | 1 | External direction input; its edges blank the comparator |
| enable_i | input | 1 | External drive enable; its edges blank the comparator |
| brake_i | input | 1 | Bridge is braking; trips are not accepted |
| near_zero_i | input | 1 | Bridge current is close to zero |
| off_cnt_i | input | CNT_W | Programmed off-time in cycles, captured at each accepted trip |
| blank_cnt_i | input | CNT_W | Blank-time in cycles, captured at each blank start |
| chop_o | output | 1 | Off-time running |
| decay_o | output | 2 | 0 drive, 1 fast decay, 2 slow decay, 3 all off |
| trip_pulse_o | output | 1 | One-cycle strobe for each accepted trip |

## Verification
The assertions assume that `off_cnt_i` and `blank_cnt_i` are not changed in the cycle when they are captured. They also assume that `near_zero_i` is only meaningful while an off-time runs. The stimulus changes the counts only while the block is idle and its blanking has run out, and it drives every input on the falling edge. The stimulus covers these cases:
- off-time counts of zero and one, which give the shortest sequences;
- a count whose 13 percent rounds to zero, to exercise the one-cycle minimum;
- `trip_i` held high across whole off-times and blanking windows, so that every rejection window is reached at both of its ends.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    DK_DRIVE = 2'd0,
    DK_FAST  = 2'd1,
    DK_SLOW  = 2'd2,
    DK_HIZ   = 2'd3
  } decay_e;

  localparam int FAST_PCT = 13;
  localparam int PCT_DIV  = 100;
endpackage

// File: rtl/chop_blank.sv
module chop_blank #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_i,
  input  logic             enable_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] blank_cnt_i,
  output logic             blanked_o
);
  logic             ph_q, en_q;
  logic [CNT_W-1:0] rem_q;
  logic             edge_w;

  assign edge_w    = (phase_i ^ ph_q) | (enable_i ^ en_q);
  assign blanked_o = edge_w | (rem_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      en_q  <= 1'b0;
      rem_q <= '0;
    end else begin
      ph_q <= phase_i;
      en_q <= enable_i;
      if (edge_w || restart_i)
        rem_q <= blank_cnt_i;
      else if (rem_q != '0)
        rem_q <= rem_q - 1'b1;
    end
  end

  // R7: a restart with a nonzero count leaves the comparator blanked next cycle
  p_restart_blanks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && blank_cnt_i != '0) |=> blanked_o);

  // R6: an input edge with a nonzero count keeps blanking into the next cycle
  p_edge_blanks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && blank_cnt_i != '0) |=> blanked_o);
endmodule

// File: rtl/chop_fast_split.sv
module chop_fast_split
  import chop_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] off_i,
  output logic [CNT_W-1:0] off_eff_o,
  output logic [CNT_W-1:0] fast_o
);
  localparam int PW = CNT_W + 4;

  logic [PW-1:0] prod_w;
  logic [PW-1:0] quot_w;

  assign off_eff_o = (off_i == '0) ? CNT_W'(1) : off_i;
  assign prod_w    = PW'(off_eff_o) * PW'(FAST_PCT);
  assign quot_w    = prod_w / PW'(PCT_DIV);
  assign fast_o    = (quot_w == '0) ? CNT_W'(1) : quot_w[CNT_W-1:0];

  // R4: fast portion is never longer than the effective off-time
  always_comb begin
    a_fast_fits_r4: assert (fast_o <= off_eff_o && fast_o != '0);
  end
endmodule

// File: rtl/chop_offtime_seq.sv
module chop_offtime_seq
  import chop_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int DEAD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] off_i,
  input  logic             near_zero_i,
  output logic             chop_o,
  output logic             expire_o,
  output decay_e           decay_o
);
  localparam int TW = CNT_W + 2;
  localparam logic [TW-1:0] DEAD_T = TW'(DEAD_CYC);

  logic [CNT_W-1:0] off_eff_w, fast_w;
  logic [CNT_W-1:0] off_q, fast_q;
  logic [TW-1:0]    e_q;
  logic             chop_q, nz_q;
  logic [TW-1:0]    total_w, fast_end_w;
  logic             in_dead_w, in_fast_w;

  chop_fast_split #(.CNT_W(CNT_W)) u_split (
    .off_i     (off_i),
    .off_eff_o (off_eff_w),
    .fast_o    (fast_w)
  );

  assign total_w    = DEAD_T + TW'(off_q);
  assign fast_end_w = DEAD_T + TW'(fast_q);
  assign in_dead_w  = chop_q && (e_q < DEAD_T);
  assign in_fast_w  = chop_q && !in_dead_w && (e_q < fast_end_w);
  assign expire_o   = chop_q && (e_q == total_w - 1'b1);
  assign chop_o     = chop_q;

  always_comb begin
    if (!chop_q)
      decay_o = DK_DRIVE;
    else if (in_dead_w)
      decay_o = DK_HIZ;
    else if (in_fast_w)
      decay_o = (nz_q || near_zero_i) ? DK_HIZ : DK_FAST;
    else
      decay_o = DK_SLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chop_q <= 1'b0;
      nz_q   <= 1'b0;
      e_q    <= '0;
      off_q  <= '0;
      fast_q <= '0;
    end else if (start_i) begin
      chop_q <= 1'b1;
      nz_q   <= 1'b0;
      e_q    <= '0;
      off_q  <= off_eff_w;
      fast_q <= fast_w;
    end else if (chop_q) begin
      if (in_fast_w && near_zero_i)
        nz_q <= 1'b1;
      if (expire_o)
        chop_q <= 1'b0;
      else
        e_q <= e_q + 1'b1;
    end
  end

  // R3: the elapsed counter never runs past the off-time length
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chop_q |-> (e_q < total_w));

  // R5: once near-zero is latched, the fast portion stays all-off
  p_hiz_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nz_q && in_fast_w) |-> (decay_o == DK_HIZ));

  // R3: expiry ends the off-time on the next edge
  p_expire_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !start_i) |=> !chop_q);
endmodule

// File: rtl/chop_ctl.sv
module chop_ctl
  import chop_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int DEAD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip_i,
  input  logic             phase_i,
  input  logic             enable_i,
  input  logic             brake_i,
  input  logic             near_zero_i,
  input  logic [CNT_W-1:0] off_cnt_i,
  input  logic [CNT_W-1:0] blank_cnt_i,
  output logic             chop_o,
  output logic [1:0]       decay_o,
  output logic             trip_pulse_o
);
  logic   blanked_w, expire_w, chop_w, accept_w, pulse_q;
  decay_e decay_w;

  chop_blank #(.CNT_W(CNT_W)) u_blank (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_i     (phase_i),
    .enable_i    (enable_i),
    .restart_i   (expire_w),
    .blank_cnt_i (blank_cnt_i),
    .blanked_o   (blanked_w)
  );

  assign accept_w = trip_i && enable_i && !brake_i && !blanked_w && !chop_w;

  chop_offtime_seq #(.CNT_W(CNT_W), .DEAD_CYC(DEAD_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept_w),
    .off_i       (off_cnt_i),
    .near_zero_i (near_zero_i),
    .chop_o      (chop_w),
    .expire_o    (expire_w),
    .decay_o     (decay_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= accept_w;
  end

  assign chop_o       = chop_w;
  assign decay_o      = decay_w;
  assign trip_pulse_o = pulse_q;

  // R2: the strobe lasts one cycle and coincides with a running off-time
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse_o |=> !trip_pulse_o);
  p_pulse_with_chop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse_o |-> chop_o);

  // R6: a trip seen while blanked gives no strobe
  p_blanked_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blanked_w && !chop_o) |=> !trip_pulse_o);

  // R8: braking or disabled bridge never yields a strobe
  p_brake_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_i || !enable_i) |=> !trip_pulse_o);

  // R9: outside the off-time the bridge is driven
  p_idle_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chop_o |-> (decay_o == 2'd0));
endmodule

// File: tb/chop_ctl_tb.sv
module chop_ctl_tb;
  localparam int CW   = 12;
  localparam int DEAD = 4;
  localparam int NV   = 6;

  localparam int V_OFF  [NV] = '{100, 7, 1, 0, 250, 23};
  localparam int V_BLK  [NV] = '{5, 0, 3, 9, 2, 1};
  localparam int V_FAST [NV] = '{13, 1, 1, 1, 32, 2};
  localparam int V_SLOW [NV] = '{87, 6, 0, 0, 218, 21};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip = 1'b0, phase = 1'b0, enable = 1'b0, brake = 1'b0, nz = 1'b0;
  logic [CW-1:0] offc = '0, blkc = '0;
  logic chop, pulse;
  logic [1:0] decay;

  int checks = 0, fails = 0;
  int n_off, n_fast, n_slow, n_len, n_pulse, n;
  bit done = 1'b0;

  always #5 clk = ~clk;

  chop_ctl #(.CNT_W(CW), .DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .trip_i(trip), .phase_i(phase),
    .enable_i(enable), .brake_i(brake), .near_zero_i(nz),
    .off_cnt_i(offc), .blank_cnt_i(blkc),
    .chop_o(chop), .decay_o(decay), .trip_pulse_o(pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) @(negedge clk);
  endtask

  // Trip, then tally one whole off-time. nzmode: 0 none, 1 one-cycle pulse at first fast cycle, 2 held
  task automatic run_chop(input int nzmode);
    int idx;
    n_off = 0; n_fast = 0; n_slow = 0; n_len = 0; n_pulse = 0; idx = 0;
    trip = 1'b1;
    for (int i = 0; i < 100 && !chop; i++) @(negedge clk);
    trip = 1'b0;
    while (n_len < 10000) begin
      nz = (nzmode == 2) || (nzmode == 1 && idx == DEAD);
      #1;
      if (!chop) break;
      if (decay == 2'd3) n_off++;
      if (decay == 2'd1) n_fast++;
      if (decay == 2'd2) n_slow++;
      if (pulse) n_pulse++;
      n_len++; idx++;
      @(negedge clk);
    end
    nz = 1'b0;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    #1;
    chk(chop == 1'b0, "R1 chop", chop, 0);
    chk(decay == 2'd0, "R1 decay", decay, 0);
    chk(pulse == 1'b0, "R1 pulse", pulse, 0);
    @(negedge clk);
    rst_n = 1'b1;
    enable = 1'b1;
    blkc = CW'(4);
    idle(10);

    // Table walk: R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      offc = CW'(V_OFF[v]);
      blkc = CW'(V_BLK[v]);
      idle(V_BLK[v] + 4);
      run_chop(0);
      chk(n_pulse == 1, "R2 pulse count", n_pulse, 1);
      chk(n_len == DEAD + ((V_OFF[v] == 0) ? 1 : V_OFF[v]), "R3 length", n_len,
          DEAD + ((V_OFF[v] == 0) ? 1 : V_OFF[v]));
      chk(n_off == DEAD, "R4 dead", n_off, DEAD);
      chk(n_fast == V_FAST[v], "R4 fast", n_fast, V_FAST[v]);
      chk(n_slow == V_SLOW[v], "R4 slow", n_slow, V_SLOW[v]);
      chk(decay == 2'd0, "R9 decay after", decay, 0);
    end

    // R5: held near-zero and one-cycle near-zero
    offc = CW'(100); blkc = CW'(3);
    idle(8);
    run_chop(2);
    chk(n_fast == 0, "R5 held fast", n_fast, 0);
    chk(n_off == DEAD + 13, "R5 held off", n_off, DEAD + 13);
    chk(n_slow == 87, "R5 held slow", n_slow, 87);
    idle(8);
    run_chop(1);
    chk(n_fast == 0, "R5 pulse fast", n_fast, 0);
    chk(n_off == DEAD + 13, "R5 pulse off", n_off, DEAD + 13);
    chk(n_slow == 87, "R5 pulse slow", n_slow, 87);

    // R6: phase edge blanking, trip held from the edge
    offc = CW'(20); blkc = CW'(6);
    idle(10);
    phase = ~phase; trip = 1'b1; n = 0;
    for (int i = 0; i < 50 && !chop; i++) begin @(posedge clk); @(negedge clk); n++; end
    chk(n == 6 + 2, "R6 phase edge", n, 8);
    trip = 1'b0;
    for (int i = 0; i < 100 && chop; i++) @(negedge clk);
    idle(10);
    // R6: enable rising edge blanking
    enable = 1'b0; idle(10);
    enable = 1'b1; trip = 1'b1; n = 0;
    for (int i = 0; i < 50 && !chop; i++) begin @(posedge clk); @(negedge clk); n++; end
    chk(n == 6 + 2, "R6 enable edge", n, 8);

    // R7: trip still held; count pulses during off-time and the gap after it
    n_pulse = 0;
    for (int i = 0; i < 100 && chop; i++) begin if (pulse) n_pulse++; @(negedge clk); end
    chk(n_pulse == 1, "R7 ignored during chop", n_pulse, 1);
    n = 0;
    for (int i = 0; i < 50 && !chop; i++) begin n++; @(negedge clk); end
    chk(n == 6 + 1, "R7 gap", n, 7);
    trip = 1'b0;
    for (int i = 0; i < 100 && chop; i++) @(negedge clk);
    idle(10);

    // R8: braking and disabled bridge
    brake = 1'b1; trip = 1'b1; n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (chop || pulse || decay != 2'd0) n++; end
    chk(n == 0, "R8 brake", n, 0);
    trip = 1'b0; brake = 1'b0;
    enable = 1'b0; idle(10);
    trip = 1'b1; n = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (chop || pulse) n++; end
    chk(n == 0, "R8 disabled", n, 0);
    trip = 1'b0;
    #1;
    chk(decay == 2'd0, "R9 idle decay", decay, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule